// File: doc/BRIEF.md
# Instruction RAM Region Register

This block holds one 32-bit control word that places an on-chip instruction RAM in the physical address map and switches it on or off. Software reaches the word through a coprocessor-style access port that carries four select fields, a read/write strobe, write data and a privilege flag. Only privileged software may touch it. A user-mode access to it raises an undefined-instruction trap instead of completing.

The RAM size is not programmable. A static configuration input supplies it, and the register shows that size in a read-only field. The base address is always aligned to the RAM size, because base bits that fall inside the RAM are ignored. A fetch-side comparator uses the current base, enable and size to decide whether each fetch address falls in the region. When it does, the comparator raises a hit flag and gives the offset into the RAM. At reset the base is zero and the cache-mode bit is clear. The enable bit takes its value from a boot pin, so the core can start executing out of the RAM at address zero.

The access port has no back-pressure. An access is presented for one cycle with `acc_valid` high. It is always accepted in that cycle, and read data and trap are valid combinationally in the same cycle.

Top module: `itcm_region_ctrl`

## Requirements
- R1: A privileged read that selects the register returns the word {effective base in [31:12], zeros in [11:7], size code in [6:2], cache-mode in [1], enable in [0]}. `acc_rdata` is zero in every cycle without such a read.
- R2: Legal size codes and their sizes are 00000 = no RAM, 00011 = 4 KB, 00100 = 8 KB, 00101 = 16 KB, 00110 = 32 KB and 00111 = 64 KB. The read field shows the configured code when it is legal for the instance and 00000 otherwise.
- R3: Writes to the register do not change the size field, and bits [11:7] always read as zero.
- R4: Base bits 12 up to log2(size)−1 read back as zero and take no part in matching. The stored base bits above them are kept.
- R5: After reset the base is 0 and the cache-mode bit is 0. The enable bit equals `boot_enable` sampled during reset.
- R6: A user-mode access (`acc_priv`=0) that selects the register raises `acc_undef` for that cycle, returns zero read data and leaves the register unchanged.
- R7: The register is selected only when opcode-A=0, primary=9, secondary=1 and opcode-B=1. Any other select value does not change it, does not trap and reads zero.
- R8: `fetch_hit` is 1 exactly when enable=1, the size is not zero, and fetch address bits [31:log2(size)] equal the effective base bits.
- R9: `ram_index` equals the fetch address modulo the RAM size, and is 0 when the size is zero.
- R10: An accepted write takes effect at the next clock edge, so matching in the following cycle uses the new base and enable.
- R11: A reserved size code, or a legal code above the instance's `MAX_LG` limit, counts as no RAM and never produces a hit.
- R12: `region_cache_mode` follows the stored cache-mode bit, which is bit 1 of the last accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_enable | input | 1 | Enable value loaded during reset |
| cfg_size_code | input | 5 | Static RAM-size code |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_opc_a | input | 3 | Opcode-A select field |
| acc_reg_n | input | 4 | Primary register select |
| acc_reg_m | input | 4 | Secondary register select |
| acc_opc_b | input | 3 | Opcode-B select field |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | 1 = privileged access |
| acc_rdata | output | 32 | Read data |
| acc_undef | output | 1 | Undefined-instruction trap |
| fetch_addr | input | 32 | Fetch address to classify |
| fetch_hit | output | 1 | Fetch falls in the RAM region |
| region_cache_mode | output | 1 | Stored cache-mode bit |
| ram_index | output | MAX_LG | Offset of the fetch inside the RAM |

## Verification
The bench builds two instances side by side and drives them with the same stimulus. One uses `MAX_LG`=16, which reaches every legal size up to 64 KB. The other uses `MAX_LG`=13, so the 16 KB, 32 KB and 64 KB codes count as out-of-range for it. With the two together, the base masking at each alignment and the fall-back of an unsupported code to no-RAM behaviour can both be observed on the same stored register.

// File: rtl/itcm_pkg.sv
package itcm_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned BASE_LSB = 12;
  localparam int unsigned BASE_W   = REG_W - BASE_LSB;

  // register select values
  localparam logic [2:0] SEL_OPC_A = 3'd0;
  localparam logic [3:0] SEL_REG_N = 4'd9;
  localparam logic [3:0] SEL_REG_M = 4'd1;
  localparam logic [2:0] SEL_OPC_B = 3'd1;

  // size code range: log2(bytes) = code + CODE_OFS
  localparam int unsigned CODE_MIN = 3;
  localparam int unsigned CODE_MAX = 7;
  localparam int unsigned CODE_OFS = 9;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic              cache;
    logic              en;
  } itcm_ctrl_t;
endpackage

// File: rtl/itcm_size_decode.sv
module itcm_size_decode
  import itcm_pkg::*;
#(
  parameter int unsigned MAX_LG = 16
) (
  input  logic [4:0] code_i,
  output logic       size_ok_o,
  output logic [4:0] lg_o,
  output logic [4:0] code_shown_o
);
  always_comb begin
    size_ok_o    = 1'b0;
    lg_o         = 5'(BASE_LSB);
    code_shown_o = 5'd0;
    if ((int'(code_i) >= int'(CODE_MIN)) && (int'(code_i) <= int'(CODE_MAX)) &&
        ((int'(code_i) + int'(CODE_OFS)) <= int'(MAX_LG))) begin
      size_ok_o    = 1'b1;
      lg_o         = code_i + 5'(CODE_OFS);
      code_shown_o = code_i;
    end
  end
endmodule

// File: rtl/itcm_access_decode.sv
module itcm_access_decode
  import itcm_pkg::*;
(
  input  logic       valid_i,
  input  logic       write_i,
  input  logic       priv_i,
  input  logic [2:0] opc_a_i,
  input  logic [3:0] reg_n_i,
  input  logic [3:0] reg_m_i,
  input  logic [2:0] opc_b_i,
  output logic       sel_o,
  output logic       rd_en_o,
  output logic       wr_en_o,
  output logic       trap_o
);
  logic addr_match;
  assign addr_match = (opc_a_i == SEL_OPC_A) && (reg_n_i == SEL_REG_N) &&
                      (reg_m_i == SEL_REG_M) && (opc_b_i == SEL_OPC_B);
  assign sel_o   = valid_i && addr_match;
  assign trap_o  = sel_o && !priv_i;
  assign rd_en_o = sel_o && priv_i && !write_i;
  assign wr_en_o = sel_o && priv_i && write_i;
endmodule

// File: rtl/itcm_region_reg.sv
module itcm_region_reg
  import itcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_en_i,
  input  logic              wr_en_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              cache_i,
  input  logic              en_i,
  output itcm_ctrl_t        ctrl_o
);
  itcm_ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.base  <= '0;
      ctrl_q.cache <= 1'b0;
      ctrl_q.en    <= boot_en_i;
    end else if (wr_en_i) begin
      ctrl_q.base  <= base_i;
      ctrl_q.cache <= cache_i;
      ctrl_q.en    <= en_i;
    end
  end

  assign ctrl_o = ctrl_q;

  // R10: accepted write is visible one edge later
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (ctrl_q.base == $past(base_i)) && (ctrl_q.en == $past(en_i)) &&
                (ctrl_q.cache == $past(cache_i)));
endmodule

// File: rtl/itcm_region_match.sv
module itcm_region_match
  import itcm_pkg::*;
#(
  parameter int unsigned MAX_LG = 16
) (
  input  logic [BASE_W-1:0] base_raw_i,
  input  logic              en_i,
  input  logic              size_ok_i,
  input  logic [4:0]        lg_i,
  input  logic [REG_W-1:0]  fetch_addr_i,
  output logic [BASE_W-1:0] eff_base_o,
  output logic              hit_o,
  output logic [MAX_LG-1:0] ram_index_o
);
  logic [REG_W-1:0] keep_mask;
  logic [REG_W-1:0] base_full;

  for (genvar i = 0; i < REG_W; i++) begin : g_mask
    assign keep_mask[i] = (5'(i) >= lg_i);
  end

  assign base_full   = {base_raw_i, {BASE_LSB{1'b0}}};
  assign eff_base_o  = base_raw_i & keep_mask[REG_W-1:BASE_LSB];
  assign hit_o       = en_i && size_ok_i &&
                       (((fetch_addr_i ^ base_full) & keep_mask) == '0);
  assign ram_index_o = size_ok_i ? (fetch_addr_i[MAX_LG-1:0] & ~keep_mask[MAX_LG-1:0])
                                 : '0;
endmodule

// File: rtl/itcm_region_ctrl.sv
module itcm_region_ctrl
  import itcm_pkg::*;
#(
  parameter int unsigned MAX_LG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_enable,
  input  logic [4:0]        cfg_size_code,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [2:0]        acc_opc_a,
  input  logic [3:0]        acc_reg_n,
  input  logic [3:0]        acc_reg_m,
  input  logic [2:0]        acc_opc_b,
  input  logic [31:0]       acc_wdata,
  input  logic              acc_priv,
  output logic [31:0]       acc_rdata,
  output logic              acc_undef,
  input  logic [31:0]       fetch_addr,
  output logic              fetch_hit,
  output logic              region_cache_mode,
  output logic [MAX_LG-1:0] ram_index
);
  localparam int unsigned IDX_W = MAX_LG;

  logic              sel, rd_en, wr_en, trap;
  logic              size_ok;
  logic [4:0]        lg, code_shown;
  itcm_ctrl_t        ctrl;
  logic [BASE_W-1:0] eff_base;
  logic [IDX_W-1:0]  idx;
  logic              unused_wbits;

  assign unused_wbits = ^acc_wdata[11:2];

  itcm_access_decode u_acc (
    .valid_i (acc_valid), .write_i (acc_write), .priv_i (acc_priv),
    .opc_a_i (acc_opc_a), .reg_n_i (acc_reg_n), .reg_m_i (acc_reg_m),
    .opc_b_i (acc_opc_b), .sel_o (sel), .rd_en_o (rd_en),
    .wr_en_o (wr_en), .trap_o (trap)
  );

  itcm_size_decode #(.MAX_LG(MAX_LG)) u_size (
    .code_i (cfg_size_code), .size_ok_o (size_ok), .lg_o (lg),
    .code_shown_o (code_shown)
  );

  itcm_region_reg u_reg (
    .clk (clk), .rst_n (rst_n), .boot_en_i (boot_enable), .wr_en_i (wr_en),
    .base_i (acc_wdata[31:12]), .cache_i (acc_wdata[1]), .en_i (acc_wdata[0]),
    .ctrl_o (ctrl)
  );

  itcm_region_match #(.MAX_LG(MAX_LG)) u_match (
    .base_raw_i (ctrl.base), .en_i (ctrl.en), .size_ok_i (size_ok), .lg_i (lg),
    .fetch_addr_i (fetch_addr), .eff_base_o (eff_base), .hit_o (fetch_hit),
    .ram_index_o (idx)
  );

  assign acc_rdata         = rd_en ? {eff_base, 5'b0, code_shown, ctrl.cache, ctrl.en} : '0;
  assign acc_undef         = trap;
  assign region_cache_mode = ctrl.cache;
  assign ram_index         = idx;

  // R6: trapped access returns nothing and changes nothing
  assert_trap_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |-> (acc_rdata == '0));
  assert_trap_keeps_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |=> $stable(ctrl));
  // R7: accesses to other selects leave the register alone
  assert_unsel_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !sel) |=> $stable(ctrl));
  // R11: no RAM, no hit
  assert_reserved_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !size_ok |-> !fetch_hit);
  // R9: index stays inside the RAM
  assert_index_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    size_ok |-> ((32'(ram_index) >> lg) == 0));
  // R8: hit requires enable
  assert_hit_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hit |-> ctrl.en);
endmodule

// File: tb/tb_itcm_region_ctrl.sv
module tb_itcm_region_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, boot_enable = 1'b0;
  logic [4:0]  cfg_size_code = 5'd7;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
  logic [2:0]  acc_opc_a = 3'd0, acc_opc_b = 3'd0;
  logic [3:0]  acc_reg_n = 4'd0, acc_reg_m = 4'd0;
  logic [31:0] acc_wdata = '0, fetch_addr = '0;
  logic [31:0] rd_a, rd_b;
  logic        und_a, und_b, hit_a, hit_b, cm_a, cm_b;
  logic [15:0] idx_a;
  logic [12:0] idx_b;

  itcm_region_ctrl #(.MAX_LG(16)) dut (
    .clk, .rst_n, .boot_enable, .cfg_size_code, .acc_valid, .acc_write,
    .acc_opc_a, .acc_reg_n, .acc_reg_m, .acc_opc_b, .acc_wdata, .acc_priv,
    .acc_rdata(rd_a), .acc_undef(und_a), .fetch_addr, .fetch_hit(hit_a),
    .region_cache_mode(cm_a), .ram_index(idx_a));

  itcm_region_ctrl #(.MAX_LG(13)) dut_small (
    .clk, .rst_n, .boot_enable, .cfg_size_code, .acc_valid, .acc_write,
    .acc_opc_a, .acc_reg_n, .acc_reg_m, .acc_opc_b, .acc_wdata, .acc_priv,
    .acc_rdata(rd_b), .acc_undef(und_b), .fetch_addr, .fetch_hit(hit_b),
    .region_cache_mode(cm_b), .ram_index(idx_b));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [19:0] m_base;
  logic m_cache, m_en;

  function automatic int lg_of(int maxlg);
    int c = int'(cfg_size_code);
    if (c >= 3 && c <= 7 && c + 9 <= maxlg) return c + 9;
    return 0;
  endfunction

  function automatic logic [31:0] exp_rd(int maxlg);
    int lg = lg_of(maxlg);
    logic [31:0] keep = (lg != 0) ? ~((32'd1 << lg) - 1) : 32'hFFFF_FFFF;
    logic [31:0] eb = {m_base, 12'b0} & keep;
    return {eb[31:12], 5'b0, (lg != 0) ? cfg_size_code : 5'd0, m_cache, m_en};
  endfunction

  function automatic logic exp_hit(int maxlg, logic [31:0] fa);
    int lg = lg_of(maxlg);
    if (lg == 0 || !m_en) return 1'b0;
    return ((fa ^ {m_base, 12'b0}) >> lg) == 0;
  endfunction

  function automatic logic [31:0] exp_idx(int maxlg, logic [31:0] fa);
    int lg = lg_of(maxlg);
    if (lg == 0) return 32'd0;
    return fa & ((32'd1 << lg) - 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_fetch(logic [31:0] fa, string tag);
    @(negedge clk);
    fetch_addr = fa;
    #1;
    chk({tag, " hit/64K"}, 32'(hit_a), 32'(exp_hit(16, fa)));
    chk({tag, " hit/8K"},  32'(hit_b), 32'(exp_hit(13, fa)));
    chk({tag, " index/64K"}, 32'(idx_a), exp_idx(16, fa));
    chk({tag, " index/8K"},  32'(idx_b), exp_idx(13, fa));
  endtask

  task automatic access(logic w, logic [2:0] oa, logic [3:0] rn, logic [3:0] rm,
                        logic [2:0] ob, logic [31:0] wd, logic pv, string tag);
    logic sel;
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_opc_a = oa; acc_reg_n = rn;
    acc_reg_m = rm; acc_opc_b = ob; acc_wdata = wd; acc_priv = pv;
    #1;
    sel = (oa == 3'd0) && (rn == 4'd9) && (rm == 4'd1) && (ob == 3'd1);
    chk({tag, " undef"}, 32'(und_a), 32'(sel && !pv));
    chk({tag, " undef/small"}, 32'(und_b), 32'(sel && !pv));
    chk({tag, " rdata/64K"}, rd_a, (sel && pv && !w) ? exp_rd(16) : 32'd0);
    chk({tag, " rdata/8K"},  rd_b, (sel && pv && !w) ? exp_rd(13) : 32'd0);
    @(posedge clk);
    if (sel && pv && w) begin
      m_base = wd[31:12]; m_cache = wd[1]; m_en = wd[0];
    end
    #1 acc_valid = 0;
  endtask

  task automatic rd(string tag);
    access(1'b0, 3'd0, 4'd9, 4'd1, 3'd1, 32'd0, 1'b1, tag);
  endtask

  task automatic wr(logic [31:0] wd, string tag);
    access(1'b1, 3'd0, 4'd9, 4'd1, 3'd1, wd, 1'b1, tag);
  endtask

  task automatic do_reset(logic boot);
    @(negedge clk);
    rst_n = 0; boot_enable = boot;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_base = '0; m_cache = 0; m_en = boot;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_base = '0; m_cache = 0; m_en = 0;

    // R5: boot pin high enables region at base 0
    cfg_size_code = 5'd7;
    do_reset(1'b1);
    rd("R5 reset boot=1");
    chk("R12 reset cache", 32'(cm_a), 32'd0);
    check_fetch(32'h0000_1234, "R5 R11 boot hit");
    do_reset(1'b0);
    rd("R5 reset boot=0");
    check_fetch(32'h0000_0000, "R8 disabled");

    // R3 R4 R1: 8KB, write with size and unused bits set
    cfg_size_code = 5'd4;
    wr(32'h1234_5FFF, "R3 write");
    rd("R1 R3 R4 readback");
    chk("R12 cache set", 32'(cm_a), 32'd1);
    check_fetch(32'h1234_4ABC, "R8 R9 inside");
    check_fetch(32'h1234_6000, "R8 outside");
    check_fetch(32'h1234_5FFF, "R4 ignored base bit");

    // R2 R4 at 64KB: dut_small treats code 7 as reserved
    cfg_size_code = 5'd7;
    rd("R2 64K code");
    check_fetch(32'h1234_BEEF, "R4 R11 64K");

    // R10: disable write then immediate fetch next cycle
    wr(32'h1234_0002, "R10 disable");
    check_fetch(32'h1234_0010, "R10 after disable");
    wr(32'h0040_0001, "R10 move");
    check_fetch(32'h0040_0100, "R10 new base");

    // R6: user accesses trap and change nothing
    access(1'b1, 3'd0, 4'd9, 4'd1, 3'd1, 32'hFFFF_F003, 1'b0, "R6 user write");
    access(1'b0, 3'd0, 4'd9, 4'd1, 3'd1, 32'd0, 1'b0, "R6 user read");
    rd("R6 unchanged");
    chk("R6 cache unchanged", 32'(cm_a), 32'd0);

    // R7: each select field off by one
    access(1'b1, 3'd1, 4'd9, 4'd1, 3'd1, 32'hABCD_E003, 1'b1, "R7 opc_a");
    access(1'b1, 3'd0, 4'd8, 4'd1, 3'd1, 32'hABCD_E003, 1'b1, "R7 reg_n");
    access(1'b1, 3'd0, 4'd9, 4'd0, 3'd1, 32'hABCD_E003, 1'b1, "R7 reg_m");
    access(1'b1, 3'd0, 4'd9, 4'd1, 3'd0, 32'hABCD_E003, 1'b0, "R7 opc_b user");
    access(1'b0, 3'd0, 4'd9, 4'd1, 3'd2, 32'd0, 1'b1, "R7 read other");
    rd("R7 unchanged");
    chk("R7 cache unchanged", 32'(cm_a), 32'd0);

    // R11 R2: reserved and zero sizes
    cfg_size_code = 5'd9;
    rd("R2 reserved read");
    check_fetch(32'h0040_0000, "R11 reserved");
    cfg_size_code = 5'd0;
    check_fetch(32'h0040_0004, "R11 R9 zero size");
    cfg_size_code = 5'd3;
    check_fetch(32'h0040_0FFC, "R8 R9 4K");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int k = $urandom_range(0, 9);
      logic [31:0] fa;
      cfg_size_code = (k < 8) ? 5'(k) : 5'($urandom_range(0, 31));
      case ($urandom_range(0, 5))
        0, 1: wr({$urandom()} | 32'($urandom_range(0, 1)), "R10 rnd write");
        2:    rd("R1 rnd read");
        3:    access(1'($urandom_range(0, 1)), 3'd0, 4'd9, 4'd1, 3'd1,
                     $urandom(), 1'b0, "R6 rnd user");
        4:    access(1'b1, 3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
                     4'($urandom_range(0, 15)), 3'($urandom_range(0, 7)),
                     $urandom(), 1'b1, "R7 rnd select");
        default: ;
      endcase
      fa = ($urandom_range(0, 2) != 0) ? ({m_base, 12'b0} ^ 32'($urandom_range(0, 32'h1FFFF)))
                                       : $urandom();
      check_fetch(fa, "R8 R9 rnd");
      chk("R12 rnd cache", 32'(cm_b), 32'(m_cache));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule